// File: doc/BRIEF.md
# Frame-Synced Serial DAC Register Interface

This block is the digital front end of a serially loaded 10-bit digital-to-analog converter. A host drives four pins: an active-low chip select, a frame-sync strobe, a serial clock and a data line. A falling frame-sync edge opens a word. Data bits are then taken on falling serial-clock edges, most significant bit first. When sixteen bits have arrived, or when frame sync returns high before that, the collected word is decoded. The result is a 10-bit converter code plus two control flags, one for speed and one for power-down. These drive the analog section, which is not part of this block.

All four pins are asynchronous to the block's system clock. They pass through multi-stage synchronizers and edge detectors. The system clock must run at least four times faster than the serial clock. Each latch transfer comes with a one-cycle update strobe, so downstream logic can act on the new setting. In three-wire use, chip select is tied low and frame sync alone marks the words.

Top module: `sdac_frontend`

## Requirements
- R1: While chip select is high, serial clock, data and frame-sync activity is ignored: no update strobe is issued and the code and flags hold their values.
- R2: A word starts only on a falling frame-sync edge seen while chip select is low; serial clock edges outside an open word shift nothing and cause no update.
- R3: Bits are taken on falling serial-clock edges, most significant first; on the sixteenth bit the complete 16-bit word is transferred to the outputs.
- R4: Field decode of a transferred word: bits 11 down to 2 form the code (bit 11 is the code MSB), bit 14 set selects fast mode, bit 13 set selects power-down; bits 15, 12, 1 and 0 have no effect on any output.
- R5: If frame sync rises after k bits, 1 <= k <= 15, the word transferred holds those k bits right-aligned (the last bit received at bit 0) with zeros above, and it is decoded by the field layout of R4.
- R6: A frame-sync rise before any bit of the word has been received ends the word without an update.
- R7: The bit count saturates at 16: further serial clock edges and a later frame-sync rise within the same word cause no second transfer and no change to the outputs.
- R8: Every transfer raises the update strobe for exactly one system clock cycle, and the code and flags change only in a cycle where the strobe is high.
- R9: Synchronous active-low reset clears the code, both flags and the strobe to zero.
- R10: Raising chip select while a word is open abandons that word: no update is issued for it, even when frame sync then rises.
- R11: With chip select held low throughout, consecutive frame-sync-delimited words each produce their own update, and the outputs end with the last word's fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| fsync_i | input | 1 | Frame sync, falling edge opens a word, asynchronous |
| sclk_i | input | 1 | Serial clock, bits taken on falling edges, asynchronous |
| sdi_i | input | 1 | Serial data input |
| code_o | output | 10 | Latched converter code |
| fast_o | output | 1 | Speed select flag, 1 = fast |
| pdown_o | output | 1 | Power-down flag, 1 = powered down |
| update_o | output | 1 | One-cycle strobe for each latch transfer |

## Verification
A pin change reaches the outputs four system clock edges later: two synchronizer stages, one framer register and one output register. So the code, flags and strobe change on the fourth edge after the qualifying serial-clock fall or frame-sync rise. The bench always waits twelve system cycles after the last pin change of a word before it compares the outputs. It counts update strobes with a monitor that samples on the falling system clock edge, so each strobe is seen exactly once. A strobe that is still high on the next sample is reported as a pulse-width failure.

// File: rtl/sdac_pkg.sv
// Package sdac_pkg
// Purpose : shared constants and types for the serial DAC front end.
// Assumes : one 16-bit word per frame; field positions fixed by the word layout.
package sdac_pkg;
    localparam int unsigned WORD_W   = 16;
    localparam int unsigned CODE_W   = 10;
    localparam int unsigned CODE_LSB = 2;
    localparam int unsigned FAST_POS = 14;
    localparam int unsigned PDN_POS  = 13;
    localparam int unsigned CNT_W    = $clog2(WORD_W + 1);

    // Decoded converter setting
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              fast;
        logic              pdown;
    } dac_setting_t;
endpackage

// File: rtl/sdac_sync.sv
// Module sdac_sync
// Purpose : multi-stage synchronizer for a vector of asynchronous pins.
// Assumes : STAGES >= 2; each bit is synchronized independently.
module sdac_sync #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the pin level through the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[b]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], d_i[b]};
            end
        end

        assign q_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/sdac_edge.sv
// Module sdac_edge
// Purpose : rising and falling edge detection on synchronized levels.
// Assumes : inputs are already synchronous to clk; strobes are combinational.
module sdac_edge #(
    parameter int unsigned WIDTH = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] prev_q;

    // Remember the previous synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= lvl_i;
        end
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/sdac_framer.sv
// Module sdac_framer
// Purpose : opens words on frame-sync fall, shifts bits MSB first on serial
//           clock fall, and issues a transfer on the 16th bit or an early
//           frame-sync rise.
// Assumes : edge strobes are single-cycle and synchronous to clk.
module sdac_framer
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act_i,
    input  logic              fs_fall_i,
    input  logic              fs_rise_i,
    input  logic              sck_fall_i,
    input  logic              sdi_i,
    output logic              xfer_o,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  bit_cnt_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    logic              open_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shreg_q;

    logic              take_bit;
    logic [WORD_W-1:0] sh_nx;
    logic [CNT_W-1:0]  cnt_nx;
    logic              full;
    logic              early;
    logic              fire;

    // Next shift state and transfer decision for this cycle
    always_comb begin
        take_bit = open_q && cs_act_i && sck_fall_i && !fs_fall_i && (cnt_q < FULL_CNT);
        sh_nx    = take_bit ? {shreg_q[WORD_W-2:0], sdi_i} : shreg_q;
        cnt_nx   = take_bit ? cnt_q + 1'b1 : cnt_q;
        full     = take_bit && (cnt_nx == FULL_CNT);
        early    = open_q && cs_act_i && fs_rise_i && (cnt_nx != '0) && !full;
        fire     = full || early;
    end

    // Frame state, bit counter and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (!cs_act_i) begin
            open_q  <= 1'b0;
        end else if (fs_fall_i) begin
            open_q  <= 1'b1;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (open_q) begin
            shreg_q <= sh_nx;
            cnt_q   <= cnt_nx;
            if (fire || fs_rise_i) begin
                open_q <= 1'b0;
            end
        end
    end

    // Register the transfer strobe and the word it carries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_o <= 1'b0;
            word_o <= '0;
        end else begin
            xfer_o <= fire;
            if (fire) begin
                word_o <= sh_nx;
            end
        end
    end

    assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/sdac_latch.sv
// Module sdac_latch
// Purpose : decodes a transferred word into code and flags and holds them;
//           raises a one-cycle update strobe with each load.
// Assumes : xfer_i is a single-cycle strobe.
module sdac_latch
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_i,
    input  logic [WORD_W-1:0] word_i,
    output dac_setting_t      set_o,
    output logic              update_o
);
    dac_setting_t dec;

    // Pick the fields out of the word
    always_comb begin
        dec.code  = word_i[CODE_LSB +: CODE_W];
        dec.fast  = word_i[FAST_POS];
        dec.pdown = word_i[PDN_POS];
    end

    // Hold the setting and pulse the strobe on each transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_o    <= '0;
            update_o <= 1'b0;
        end else begin
            update_o <= xfer_i;
            if (xfer_i) begin
                set_o <= dec;
            end
        end
    end
endmodule

// File: rtl/sdac_frontend.sv
// Module sdac_frontend
// Purpose : top of the serial DAC front end: synchronizes the pins, frames
//           16-bit words and latches code and control flags.
// Assumes : clk runs at least 4x the serial clock; pins are asynchronous.
module sdac_frontend
    import sdac_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              fsync_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic [CODE_W-1:0] code_o,
    output logic              fast_o,
    output logic              pdown_o,
    output logic              update_o
);
    // Pin vector order: {cs_n, fsync, sclk, sdi}
    localparam int unsigned NPIN = 4;
    localparam logic [NPIN-1:0] PIN_RST = 4'b1100;

    logic [NPIN-1:0]   pins_s;
    logic [1:0]        rise_s;
    logic [1:0]        fall_s;
    logic              xfer;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  bit_cnt;
    dac_setting_t      setting;

    sdac_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n_i, fsync_i, sclk_i, sdi_i}),
        .q_o   (pins_s)
    );

    // Edge detection on {fsync, sclk}
    sdac_edge #(.WIDTH(2), .RST_VAL(2'b10)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pins_s[2:1]),
        .rise_o (rise_s),
        .fall_o (fall_s)
    );

    sdac_framer u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act_i   (~pins_s[3]),
        .fs_fall_i  (fall_s[1]),
        .fs_rise_i  (rise_s[1]),
        .sck_fall_i (fall_s[0]),
        .sdi_i      (pins_s[0]),
        .xfer_o     (xfer),
        .word_o     (word),
        .bit_cnt_o  (bit_cnt)
    );

    sdac_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer_i   (xfer),
        .word_i   (word),
        .set_o    (setting),
        .update_o (update_o)
    );

    assign code_o  = setting.code;
    assign fast_o  = setting.fast;
    assign pdown_o = setting.pdown;
endmodule

// File: rtl/sdac_checker.sv
// Module sdac_checker
// Purpose : protocol properties of the serial DAC front end, bound to the top.
// Assumes : bench applies reset from time zero.
module sdac_checker
    import sdac_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_i,
    input logic [CODE_W-1:0] code_o,
    input logic              fast_o,
    input logic              pdown_o,
    input logic              update_o,
    input logic [CNT_W-1:0]  bit_cnt
);
    localparam int unsigned GUARD = SYNC_STAGES + 3;

    logic [3:0] cs_hi_cnt;
    logic       seen_clk_q;
    logic       rst_prev_q;

    // Count cycles with chip select held high (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_n_i) begin
            cs_hi_cnt <= '0;
        end else if (cs_hi_cnt != 4'hF) begin
            cs_hi_cnt <= cs_hi_cnt + 1'b1;
        end
    end

    // Track the reset level of the previous edge
    always_ff @(posedge clk) begin
        seen_clk_q <= 1'b1;
        rst_prev_q <= rst_n;
    end

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    assert_hold_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !update_o |-> $stable({code_o, fast_o, pdown_o}));

    assert_cnt_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(WORD_W));

    assert_cs_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt >= GUARD) |-> !update_o);

    // R9: outputs cleared on the edge after a reset edge
    always @(posedge clk) begin
        if (seen_clk_q && !rst_prev_q) begin
            assert_reset_clears_R9: assert (code_o == '0 && !fast_o && !pdown_o && !update_o);
        end
    end
endmodule

bind sdac_frontend sdac_checker #(.SYNC_STAGES(SYNC_STAGES)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_i   (cs_n_i),
    .code_o   (code_o),
    .fast_o   (fast_o),
    .pdown_o  (pdown_o),
    .update_o (update_o),
    .bit_cnt  (bit_cnt)
);

// File: tb/sdac_frontend_tb.sv
module sdac_frontend_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       fsync = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [9:0] code;
    logic       fast;
    logic       pdown;
    logic       update;

    int checks = 0;
    int fails  = 0;
    int upd_total = 0;
    int wide_pulses = 0;
    bit upd_prev = 1'b0;
    bit done = 1'b0;

    logic [9:0] exp_code = '0;
    logic       exp_fast = 1'b0;
    logic       exp_pd   = 1'b0;

    always #5 clk = ~clk;

    sdac_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .fsync_i(fsync),
        .sclk_i(sclk), .sdi_i(sdi), .code_o(code), .fast_o(fast),
        .pdown_o(pdown), .update_o(update)
    );

    // Strobe monitor: count pulses, flag any lasting two samples (R8)
    always @(negedge clk) begin
        if (rst_n && update) upd_total++;
        if (rst_n && update && upd_prev) wide_pulses++;
        upd_prev = rst_n && update;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Word the requirements say is transferred after n bits (R3, R5)
    function automatic logic [15:0] model_word(input logic [15:0] w, input int n);
        return (n >= 16) ? w : (w >> (16 - n));
    endfunction

    // R4 field decode applied to the bench model
    task automatic model_apply(input logic [15:0] w);
        exp_code = w[11:2];
        exp_fast = w[14];
        exp_pd   = w[13];
    endtask

    task automatic send_bit(input logic b);
        sclk = 1'b1; sdi = b; tick(4);
        sclk = 1'b0; tick(4);
    endtask

    // One frame: fs fall, n bits, extra bits, fs rise
    task automatic send_frame(input logic [15:0] w, input int n, input int extra);
        fsync = 1'b0; tick(4);
        for (int i = 0; i < n; i++) send_bit(w[15-i]);
        for (int i = 0; i < extra; i++) send_bit(1'($urandom));
        fsync = 1'b1; tick(12);
    endtask

    task automatic check_outputs(input string tag);
        check({tag, " code"}, int'(code), int'(exp_code));
        check({tag, " fast"}, int'(fast), int'(exp_fast));
        check({tag, " pdown"}, int'(pdown), int'(exp_pd));
    endtask

    // Watchdog: a hang counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hang expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int base;
        void'($urandom(32'd2024));
        tick(4);
        // R9: reset state
        check("R9 code", int'(code), 0);
        check("R9 flags", int'({fast, pdown, update}), 0);
        rst_n = 1'b1; tick(4);
        cs_n = 1'b0; tick(4);

        // R3/R4: full words, ignored bits 15,12,1,0
        base = upd_total;
        send_frame(16'hFFFF, 16, 0); model_apply(16'hFFFF);
        check("R3 update count", upd_total - base, 1);
        check_outputs("R4 all ones");
        send_frame(16'h9003, 16, 0); model_apply(16'h9003);
        check_outputs("R4 ignored bits");
        send_frame(16'h4A5C, 16, 0); model_apply(16'h4A5C);
        check_outputs("R3 msb first");

        // R2: serial clocks with no frame-sync fall
        base = upd_total;
        for (int i = 0; i < 16; i++) send_bit(1'b1);
        fsync = 1'b0; tick(2); fsync = 1'b1; tick(12);
        check("R2 no word opened", upd_total - base, 0);
        check_outputs("R2 hold");

        // R6: rise before any bit
        base = upd_total;
        send_frame(16'h0000, 0, 0);
        check("R6 no update", upd_total - base, 0);

        // R5: early rise after 9 bits
        base = upd_total;
        send_frame(16'hABCD, 9, 0); model_apply(model_word(16'hABCD, 9));
        check("R5 update count", upd_total - base, 1);
        check_outputs("R5 early");

        // R7: extra clocks after the sixteenth bit
        base = upd_total;
        send_frame(16'h2F30, 16, 5); model_apply(16'h2F30);
        check("R7 single update", upd_total - base, 1);
        check_outputs("R7 saturate");

        // R1: chip select high during a whole frame
        cs_n = 1'b1; tick(8);
        base = upd_total;
        send_frame(16'h7FFC, 16, 0);
        check("R1 no update", upd_total - base, 0);
        check_outputs("R1 hold");

        // R10: chip select raised mid-frame
        cs_n = 1'b0; tick(4);
        base = upd_total;
        fsync = 1'b0; tick(4);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        cs_n = 1'b1; tick(6);
        fsync = 1'b1; tick(12);
        check("R10 abandoned", upd_total - base, 0);
        check_outputs("R10 hold");

        // R11: three-wire, back-to-back words
        cs_n = 1'b0; tick(4);
        base = upd_total;
        send_frame(16'h1234, 16, 0);
        send_frame(16'h6C08, 16, 0); model_apply(16'h6C08);
        check("R11 two updates", upd_total - base, 2);
        check_outputs("R11 last word");

        // Random frames: mostly full words, some early ends (R3, R5, R6)
        for (int k = 0; k < 40; k++) begin
            logic [15:0] w;
            int n;
            w = 16'($urandom);
            n = (($urandom % 4) == 0) ? int'($urandom % 16) : 16;
            base = upd_total;
            send_frame(w, n, 0);
            if (n > 0) model_apply(model_word(w, n));
            check("R5 random count", upd_total - base, (n > 0) ? 1 : 0);
            check_outputs("R3 random");
        end

        // R8: every strobe lasted one cycle
        check("R8 pulse width", wide_pulses, 0);

        // R9: reset again clears the outputs
        rst_n = 1'b0; tick(3);
        check("R9 re-reset", int'({code, fast, pdown, update}), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule